// File: doc/BRIEF.md
# Predicated SIMD Multiply-Accumulate Unit

This block is the integer multiply-accumulate datapath of a vector execution pipe. Each request brings a 32-bit instruction word, the old contents of the destination vector, the two other source vectors and the governing predicate value. The block decodes the instruction word and assigns the operand roles from the opcode. In every active lane it then forms either `addend + n*m` or `addend - n*m`, truncated to the lane width. Lanes that are not active keep the old destination contents.

The element size can be 8, 16, 32 or 64 bits, over a vector whose width is a parameter (a multiple of 128 bits, 256 by default). The predicate carries one bit per vector byte. The block also returns the register indices it decodes, so that the surrounding pipe can fetch the operands. Storage of the register file, access checks and floating-point forms belong to other blocks.

Top module: `pmac_unit`

## Requirements
- R1: The element size comes from instruction bits 23:22: 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit.
- R2: For the add forms, an active lane produces `a + n*m`, truncated modulo 2^lane width.
- R3: For the subtract forms, an active lane produces `a - n*m`, truncated modulo 2^lane width.
- R4: Opcode bits 15:13 = 010 (add) or 011 (subtract) give the accumulate forms. In these forms the old destination is the addend `a`, `src_x` (the register named by bits 9:5) is `n`, and `src_m` is `m`.
- R5: Opcode bits 15:13 = 110 (add) or 111 (subtract) give the multiply forms. In these forms the old destination is the multiplicand `n`, `src_x` is the addend `a`, and `src_m` is `m`.
- R6: A lane is active when the predicate bit of its lowest-addressed byte is 1. The predicate bits of the lane's other bytes have no effect.
- R7: An inactive lane of `result` equals the same lane of `dst_old`.
- R8: An instruction is illegal in any of these cases: bits 31:24 differ from 8'b00000100, bit 21 is 1, or bits 15:13 are not one of 010, 011, 110, 111. For an illegal instruction, `illegal` is 1 and `result` equals `dst_old`.
- R9: The block takes a request when `start` is high. `valid` is high for exactly the one cycle that follows. `result` and `illegal` hold their values until the next request.
- R10: While reset is active and after it, until the first request: `valid` = 0, `illegal` = 0 and `result` = 0.
- R11: The index outputs follow the instruction word combinationally: `idx_d` = bits 4:0, `idx_x` = bits 9:5, `idx_m` = bits 20:16, `idx_pg` = bits 12:10.

Vector lanes follow the byte order: lane k of width W occupies bits `k*W +: W`, and its lowest byte is predicate bit `k*W/8`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe; takes the inputs this cycle |
| insn | input | 32 | Instruction word |
| dst_old | input | VEC_W | Old contents of the destination vector |
| src_x | input | VEC_W | Vector named by bits 9:5 |
| src_m | input | VEC_W | Vector named by bits 20:16 |
| pred | input | VEC_W/8 | Governing predicate, one bit per byte |
| idx_d | output | 5 | Destination register index |
| idx_x | output | 5 | Index of the register for bits 9:5 |
| idx_m | output | 5 | Index of the m register |
| idx_pg | output | 3 | Governing predicate index |
| result | output | VEC_W | New destination vector |
| valid | output | 1 | One-cycle strobe; `result` is ready |
| illegal | output | 1 | The last request was an illegal encoding |

## Verification
The assertions assume that `start` is never X and that, when `start` is high, the instruction word, the vectors and the predicate are valid in that same cycle, because the results are compared with the values sampled then. They also assume that reset is held low for at least one clock edge before the first request. The bench follows this: it drives every input on the falling edge, raises `start` for one cycle per request and returns the operand inputs to known values in between. It checks the results only after the rising edge that registers them.

// File: rtl/pmac_pkg.sv
// Package pmac_pkg
// Shared constants and types of the predicated multiply-accumulate unit.
// Assumes the 32-bit instruction word layout described in the brief.
package pmac_pkg;

    localparam logic [7:0] GROUP_TAG = 8'b0000_0100;

    typedef enum logic [2:0] {
        OP_ACC_ADD = 3'b010,
        OP_ACC_SUB = 3'b011,
        OP_MUL_ADD = 3'b110,
        OP_MUL_SUB = 3'b111
    } pmac_op_e;

    typedef struct packed {
        logic       legal;
        logic       sub;
        logic       dest_is_mult;
        logic [1:0] esz;
        logic [4:0] rd;
        logic [4:0] rx;
        logic [4:0] rm;
        logic [2:0] pg;
    } pmac_dec_t;

endpackage

// File: rtl/pmac_decode.sv
// Module pmac_decode
// Pulls the fields out of the instruction word and classifies the opcode.
// Purely combinational; assumes insn is stable while it is being used.
module pmac_decode
    import pmac_pkg::*;
(
    input  logic [31:0] insn,
    output pmac_dec_t   dec
);

    logic [2:0] opc;
    logic       op_known;

    // Split the fields and decide legality and operand roles.
    always_comb begin
        opc      = insn[15:13];
        op_known = (opc == OP_ACC_ADD) || (opc == OP_ACC_SUB) ||
                   (opc == OP_MUL_ADD) || (opc == OP_MUL_SUB);
        dec.legal        = (insn[31:24] == GROUP_TAG) && !insn[21] && op_known;
        dec.sub          = opc[0];
        dec.dest_is_mult = opc[2];
        dec.esz          = insn[23:22];
        dec.rd           = insn[4:0];
        dec.rx           = insn[9:5];
        dec.rm           = insn[20:16];
        dec.pg           = insn[12:10];
    end

endmodule

// File: rtl/pmac_lane_array.sv
// Module pmac_lane_array
// Every lane of one fixed element width: multiply, add or subtract, then
// merge with the old destination under a per-lane enable.
// Assumes VEC_W is a multiple of LANE_W. lane_en holds one bit per lane,
// already reduced from the byte predicate by the parent.
module pmac_lane_array #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0]        va,
    input  logic [VEC_W-1:0]        vn,
    input  logic [VEC_W-1:0]        vm,
    input  logic [VEC_W-1:0]        vold,
    input  logic [VEC_W/LANE_W-1:0] lane_en,
    input  logic                    sub,
    output logic [VEC_W-1:0]        vres
);

    localparam int N_LANES = VEC_W / LANE_W;

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] prod;
        logic [LANE_W-1:0] acc;

        // Truncated lane product and accumulation; merge with the old lane.
        always_comb begin
            prod = LANE_W'(vn[l*LANE_W +: LANE_W] * vm[l*LANE_W +: LANE_W]);
            acc  = sub ? (va[l*LANE_W +: LANE_W] - prod)
                       : (va[l*LANE_W +: LANE_W] + prod);
            vres[l*LANE_W +: LANE_W] = lane_en[l] ? acc : vold[l*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/pmac_unit.sv
// Module pmac_unit
// Top of the predicated SIMD multiply-accumulate unit. It decodes the
// instruction, assigns operand roles, evaluates all four lane widths in
// parallel, picks the width from the element-size field and registers the
// result with a one-cycle valid strobe.
// Assumes VEC_W is a multiple of 128 and that the inputs are valid with start.
module pmac_unit
    import pmac_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        insn,
    input  logic [VEC_W-1:0]   dst_old,
    input  logic [VEC_W-1:0]   src_x,
    input  logic [VEC_W-1:0]   src_m,
    input  logic [VEC_W/8-1:0] pred,
    output logic [4:0]         idx_d,
    output logic [4:0]         idx_x,
    output logic [4:0]         idx_m,
    output logic [2:0]         idx_pg,
    output logic [VEC_W-1:0]   result,
    output logic               valid,
    output logic               illegal
);

    localparam int N_SIZES = 4;

    pmac_dec_t        dec;
    logic [VEC_W-1:0] op_a;
    logic [VEC_W-1:0] op_n;
    logic [VEC_W-1:0] res_by_size [N_SIZES];
    logic [VEC_W-1:0] res_sel;

    pmac_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    // Return the decoded register indices to the pipe.
    always_comb begin
        idx_d  = dec.rd;
        idx_x  = dec.rx;
        idx_m  = dec.rm;
        idx_pg = dec.pg;
    end

    // Operand roles: the destination is either the addend or the multiplicand.
    always_comb begin
        if (dec.dest_is_mult) begin
            op_a = src_x;
            op_n = dst_old;
        end else begin
            op_a = dst_old;
            op_n = src_x;
        end
    end

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = VEC_W / LW;
        logic [NL-1:0] lane_en;

        for (genvar l = 0; l < NL; l++) begin : g_en
            assign lane_en[l] = pred[l * (LW / 8)];
        end

        pmac_lane_array #(
            .VEC_W  (VEC_W),
            .LANE_W (LW)
        ) u_lanes (
            .va      (op_a),
            .vn      (op_n),
            .vm      (src_m),
            .vold    (dst_old),
            .lane_en (lane_en),
            .sub     (dec.sub),
            .vres    (res_by_size[s])
        );
    end

    // Pick the lane width; an illegal encoding passes the old destination.
    always_comb begin
        res_sel = dec.legal ? res_by_size[dec.esz] : dst_old;
    end

    // Output register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            valid   <= 1'b0;
            illegal <= 1'b0;
        end else begin
            valid <= start;
            if (start) begin
                result  <= res_sel;
                illegal <= !dec.legal;
            end
        end
    end

    // R9: one-cycle strobe after each request
    a_r9_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    // R9: result held between requests
    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));
    // R8: an illegal request leaves the destination unchanged
    a_r8_illegal_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (start && insn[21]) |=> (illegal && result == $past(dst_old)));
    // R7: an all-zero predicate changes no lane
    a_r7_empty_pred_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pred == '0) |=> (result == $past(dst_old)));

endmodule

// File: tb/sim_pmac_unit.sv
module sim_pmac_unit;

    localparam int VW = 256;
    localparam int PW = VW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   insn = '0;
    logic [VW-1:0] dst_old = '0;
    logic [VW-1:0] src_x = '0;
    logic [VW-1:0] src_m = '0;
    logic [PW-1:0] pred = '0;
    logic [4:0]    idx_d, idx_x, idx_m;
    logic [2:0]    idx_pg;
    logic [VW-1:0] result;
    logic          valid, illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmac_unit #(.VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
        .dst_old(dst_old), .src_x(src_x), .src_m(src_m), .pred(pred),
        .idx_d(idx_d), .idx_x(idx_x), .idx_m(idx_m), .idx_pg(idx_pg),
        .result(result), .valid(valid), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input logic [7:0] top, input logic [1:0] esz,
                                       input logic b21, input logic [2:0] opc);
        return {top, esz, b21, 5'd7, opc, 3'd5, 5'd19, 5'd2};
    endfunction

    function automatic logic [VW-1:0] rvec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Reference model written from the requirements.
    function automatic logic [VW-1:0] model(input logic [31:0] iw, input logic [VW-1:0] d,
                                            input logic [VW-1:0] x, input logic [VW-1:0] m,
                                            input logic [PW-1:0] p);
        logic [VW+63:0] dd, xx, mm;
        logic [VW-1:0]  r;
        logic [63:0]    a, n, mu, v, mask;
        int             lw;
        logic [2:0]     opc;
        opc = iw[15:13];
        if (iw[31:24] != 8'h04 || iw[21] || !(opc == 3'b010 || opc == 3'b011 ||
                                               opc == 3'b110 || opc == 3'b111))
            return d;
        dd = {64'b0, d}; xx = {64'b0, x}; mm = {64'b0, m};
        r = d;
        lw = 8 << iw[23:22];
        mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        for (int l = 0; l < VW / lw; l++) begin
            if (p[l * lw / 8]) begin
                if (opc[2]) begin a = xx[l*lw +: 64]; n = dd[l*lw +: 64]; end
                else        begin a = dd[l*lw +: 64]; n = xx[l*lw +: 64]; end
                mu = mm[l*lw +: 64];
                a &= mask; n &= mask; mu &= mask;
                v = opc[0] ? (a - n * mu) : (a + n * mu);
                for (int b = 0; b < lw; b++) r[l*lw + b] = v[b];
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One request: drive on the falling edge, check after the capturing edge.
    task automatic run(input string req, input logic [31:0] iw, input logic [VW-1:0] d,
                       input logic [VW-1:0] x, input logic [VW-1:0] m, input logic [PW-1:0] p,
                       input logic exp_ill);
        logic [VW-1:0] e;
        e = model(iw, d, x, m, p);
        @(negedge clk);
        insn = iw; dst_old = d; src_x = x; src_m = m; pred = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R9 valid"}, VW'(valid), VW'(1));
        chk({req, " result"}, result, e);
        chk({req, " R8 illegal flag"}, VW'(illegal), VW'(exp_ill));
    endtask

    task automatic t_reset();
        chk("R10 reset valid", VW'(valid), '0);
        chk("R10 reset illegal", VW'(illegal), '0);
        chk("R10 reset result", result, '0);
    endtask

    task automatic t_fields();
        @(negedge clk);
        insn = 32'h04_1A_B5_6D;
        #1;
        chk("R11 idx_d",  VW'(idx_d),  VW'(insn[4:0]));
        chk("R11 idx_x",  VW'(idx_x),  VW'(insn[9:5]));
        chk("R11 idx_m",  VW'(idx_m),  VW'(insn[20:16]));
        chk("R11 idx_pg", VW'(idx_pg), VW'(insn[12:10]));
    endtask

    task automatic t_forms();
        for (int s = 0; s < 4; s++) begin
            run("R1 R2 R4 acc add",   mk(8'h04, 2'(s), 1'b0, 3'b010), rvec(), rvec(), rvec(), '1, 1'b0);
            run("R1 R3 R4 acc sub",   mk(8'h04, 2'(s), 1'b0, 3'b011), rvec(), rvec(), rvec(), '1, 1'b0);
            run("R1 R2 R5 mul add",   mk(8'h04, 2'(s), 1'b0, 3'b110), rvec(), rvec(), rvec(), '1, 1'b0);
            run("R1 R3 R5 mul sub",   mk(8'h04, 2'(s), 1'b0, 3'b111), rvec(), rvec(), rvec(), '1, 1'b0);
        end
    endtask

    task automatic t_extremes();
        for (int s = 0; s < 4; s++) begin
            run("R2 all-ones wrap", mk(8'h04, 2'(s), 1'b0, 3'b010), '1, '1, '1, '1, 1'b0);
            run("R3 zero minus",    mk(8'h04, 2'(s), 1'b0, 3'b011), '0, '1, '1, '1, 1'b0);
        end
    endtask

    task automatic t_pred();
        logic [VW-1:0] d;
        // 32-bit lanes: only non-lowest byte bits set, so every lane stays old
        d = rvec();
        run("R6 upper bits ignored", mk(8'h04, 2'd2, 1'b0, 3'b010), d, rvec(), rvec(), 32'hEEEE_EEEE, 1'b0);
        chk("R7 inactive keeps dst", result, d);
        for (int s = 0; s < 4; s++)
            run("R6 R7 sparse pred", mk(8'h04, 2'(s), 1'b0, 3'b110), rvec(), rvec(), rvec(), $urandom, 1'b0);
        run("R7 empty pred", mk(8'h04, 2'd0, 1'b0, 3'b011), rvec(), rvec(), rvec(), '0, 1'b0);
    endtask

    task automatic t_illegal();
        run("R8 opcode 000", mk(8'h04, 2'd1, 1'b0, 3'b000), rvec(), rvec(), rvec(), '1, 1'b1);
        run("R8 opcode 101", mk(8'h04, 2'd3, 1'b0, 3'b101), rvec(), rvec(), rvec(), '1, 1'b1);
        run("R8 bit21 set",  mk(8'h04, 2'd0, 1'b1, 3'b010), rvec(), rvec(), rvec(), '1, 1'b1);
        run("R8 wrong group", mk(8'h05, 2'd2, 1'b0, 3'b110), rvec(), rvec(), rvec(), '1, 1'b1);
        run("R8 legal after illegal", mk(8'h04, 2'd2, 1'b0, 3'b110), rvec(), rvec(), rvec(), '1, 1'b0);
    endtask

    task automatic t_hold();
        logic [VW-1:0] keep;
        run("R9 setup", mk(8'h04, 2'd1, 1'b0, 3'b010), rvec(), rvec(), rvec(), '1, 1'b0);
        keep = result;
        dst_old = rvec(); src_x = rvec(); src_m = rvec();
        @(negedge clk);
        chk("R9 valid is a pulse", VW'(valid), '0);
        chk("R9 result held", result, keep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_forms();
        t_extremes();
        t_pred();
        t_illegal();
        t_hold();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule